// File: doc/BRIEF.md
# Little-Endian Byte Alignment Unit

This unit pulls a word that begins at an arbitrary byte offset out of a stream of consecutive source words. Every accepted source word is joined with the word accepted before it. That earlier word sits in an internal saved-word register. A window of contiguous bytes is then taken at the offset held in a small byte-offset register. In the little-endian order used here, the upper bytes of the saved word become the lower bytes of the result, and the lower bytes of the new word fill the upper part.

Because the second operand is always the saved word, the first operation of a sequence only loads that register and yields no result. Extracting n aligned words therefore costs n+1 accepted source words. A synchronous clear empties the saved word and returns the unit to its priming phase. The byte offset is written through its own strobe and is not affected by the clear.

Top module: `le_align_unit`

## Requirements
- R1: After reset, `res_valid` is 0, `priming` is 1, `res_word` is 0 and the byte offset is 0.
- R2: A source word accepted while `priming` is 1 produces no result (`res_valid` stays 0) and drops `priming` to 0 on the next cycle.
- R3: A source word `new` accepted while `priming` is 0 gives, one clock later, `res_valid`=1 and `res_word` = bits [31:0] of the 64-bit value {new, prev} shifted right by 8×offset, where prev is the previously accepted word.
- R4: With offset 0 the result equals the saved previous word unchanged.
- R5: With offset 2, saved word 0x03020100 and new word 0x07060504 give 0x05040302.
- R6: Every accepted word replaces the saved word, so a back-to-back run of n+1 words yields exactly n valid results on consecutive cycles.
- R7: An offset written with `off_we` is used from the next accepted word on. A word accepted in the same cycle as the write still uses the old offset, and the write leaves the saved word unchanged.
- R8: Asserting `clr` sets `priming` to 1 and `res_valid` to 0 on the next cycle, and the next accepted word only primes. `clr` takes priority over a word offered in the same cycle.
- R9: In cycles without an accepted word, `res_valid` is 0 and `res_word` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear back to the priming phase |
| off_we | input | 1 | Write strobe for the byte offset |
| off_wdata | input | 2 | New byte offset (0 to 3) |
| src_valid | input | 1 | Source word is accepted this cycle |
| src_word | input | 32 | Source word |
| res_valid | output | 1 | Result word is valid (one cycle per operation) |
| res_word | output | 32 | Aligned result word |
| priming | output | 1 | Next accepted word will only load the saved register |

## Verification
A table of word pairs covers all four offsets. Counting byte patterns show which source byte lands in each result lane, and irregular patterns catch lane swaps that a counting pattern could hide. A back-to-back run of four words checks the n+1 cost and the hand-over of the saved word between cycles. Directed sequences test an offset written in the same cycle as an operation against one written while idle, and a clear issued in mid-stream, and they check that the result register holds during idle cycles.

// File: rtl/le_align_pkg.sv
package le_align_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef enum logic {PH_PRIME = 1'b0, PH_RUN = 1'b1} phase_e;
endpackage

// File: rtl/le_align_offset_reg.sv
module le_align_offset_reg #(
  parameter int unsigned OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [OFF_W-1:0] wdata,
  output logic [OFF_W-1:0] off
);
  always_ff @(posedge clk) begin
    if (rst)     off <= '0;
    else if (we) off <= wdata;
  end

  // R7: a write lands on the next cycle
  a_r7_offset_write: assert property (@(posedge clk) disable iff (rst)
    we |=> off == $past(wdata));
endmodule

// File: rtl/le_align_saved_reg.sv
module le_align_saved_reg
  import le_align_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              take,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] saved,
  output phase_e            phase
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      saved <= '0;
      phase <= PH_PRIME;
    end else if (take) begin
      saved <= word_in;
      phase <= PH_RUN;
    end
  end

  // R6: each accepted word becomes the saved word
  a_r6_saved_capture: assert property (@(posedge clk) disable iff (rst)
    (take && !clr) |=> saved == $past(word_in));
  // R8: clear returns to priming
  a_r8_clear_primes: assert property (@(posedge clk) disable iff (rst)
    clr |=> phase == PH_PRIME);
endmodule

// File: rtl/le_align_funnel.sv
module le_align_funnel
  import le_align_pkg::*;
#(
  parameter int unsigned NBYTES = 4,
  localparam int unsigned WORD_W = NBYTES * BYTE_W,
  localparam int unsigned OFF_W  = $clog2(NBYTES)
) (
  input  logic [WORD_W-1:0] prev_word,
  input  logic [WORD_W-1:0] new_word,
  input  logic [OFF_W-1:0]  off,
  output logic [WORD_W-1:0] out_word
);
  logic [2*WORD_W-1:0] joined;
  assign joined = {new_word, prev_word};

  for (genvar lane = 0; lane < NBYTES; lane++) begin : g_lane
    logic [OFF_W:0] pick;
    assign pick = {1'b0, off} + (OFF_W+1)'(lane);
    assign out_word[lane*BYTE_W +: BYTE_W] = joined[pick*BYTE_W +: BYTE_W];
  end

  // R4: offset zero passes the previous word through
  always_comb begin
    if (off == '0) a_r4_zero_offset: assert (out_word == prev_word);
  end
endmodule

// File: rtl/le_align_unit.sv
module le_align_unit
  import le_align_pkg::*;
#(
  parameter int unsigned NBYTES = 4,
  localparam int unsigned WORD_W = NBYTES * BYTE_W,
  localparam int unsigned OFF_W  = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              off_we,
  input  logic [OFF_W-1:0]  off_wdata,
  input  logic              src_valid,
  input  logic [WORD_W-1:0] src_word,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_word,
  output logic              priming
);
  logic [OFF_W-1:0]  off;
  logic [WORD_W-1:0] saved;
  logic [WORD_W-1:0] aligned;
  phase_e            phase;
  logic              take;

  assign take    = src_valid && !clr;
  assign priming = (phase == PH_PRIME);

  le_align_offset_reg #(.OFF_W(OFF_W)) u_off (
    .clk(clk), .rst(rst), .we(off_we), .wdata(off_wdata), .off(off)
  );

  le_align_saved_reg #(.WORD_W(WORD_W)) u_saved (
    .clk(clk), .rst(rst), .clr(clr), .take(take), .word_in(src_word),
    .saved(saved), .phase(phase)
  );

  le_align_funnel #(.NBYTES(NBYTES)) u_funnel (
    .prev_word(saved), .new_word(src_word), .off(off), .out_word(aligned)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_word  <= '0;
    end else begin
      res_valid <= take && (phase == PH_RUN);
      if (take && (phase == PH_RUN)) res_word <= aligned;
    end
  end

  // R2: a priming word yields no result
  a_r2_prime_silent: assert property (@(posedge clk) disable iff (rst)
    (src_valid && priming) |=> !res_valid);
  // R3: a result only follows an accepted word
  a_r3_valid_source: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(src_valid && !clr));
  // R8: clear suppresses the result
  a_r8_clear_no_result: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!res_valid && priming));
  // R9: idle cycles hold the result word
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !src_valid |=> ($stable(res_word) && !res_valid));
endmodule

// File: tb/le_align_unit_bench.sv
`timescale 1ns/1ps
module le_align_unit_bench;
  logic        clk = 1'b0;
  logic        rst, clr, off_we, src_valid;
  logic [1:0]  off_wdata;
  logic [31:0] src_word;
  logic        res_valid, priming;
  logic [31:0] res_word;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  le_align_unit u_le_align_unit (
    .clk(clk), .rst(rst), .clr(clr), .off_we(off_we), .off_wdata(off_wdata),
    .src_valid(src_valid), .src_word(src_word),
    .res_valid(res_valid), .res_word(res_word), .priming(priming)
  );

  localparam int NV = 6;
  localparam logic [31:0] TV_PREV [0:NV-1] = '{32'h03020100, 32'h03020100,
    32'h03020100, 32'h03020100, 32'hDEADBEEF, 32'hDEADBEEF};
  localparam logic [31:0] TV_NEW  [0:NV-1] = '{32'h07060504, 32'h07060504,
    32'h07060504, 32'h07060504, 32'h01234567, 32'h01234567};
  localparam logic [1:0]  TV_OFF  [0:NV-1] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd1, 2'd3};
  localparam logic [31:0] TV_EXP  [0:NV-1] = '{32'h03020100, 32'h04030201,
    32'h05040302, 32'h06050403, 32'h67DEADBE, 32'h234567DE};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive inputs for one cycle (called at a negedge), return at the next negedge
  task automatic cyc(input logic v, input logic [31:0] w);
    src_valid = v;
    src_word  = w;
    @(negedge clk);
    src_valid = 1'b0;
  endtask

  task automatic set_off(input logic [1:0] o);
    off_we = 1'b1; off_wdata = o;
    @(negedge clk);
    off_we = 1'b0;
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; clr = 1'b0; off_we = 1'b0; off_wdata = '0;
    src_valid = 1'b0; src_word = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 res_valid", {31'd0, res_valid}, 32'd0);
    check("R1 priming",   {31'd0, priming},   32'd1);
    check("R1 res_word",  res_word,           32'd0);
    // R1/R4: default offset 0 gives saved word
    cyc(1'b1, 32'hA5A5_0F0F);
    check("R2 no result on prime", {31'd0, res_valid}, 32'd0);
    check("R2 priming drops",      {31'd0, priming},   32'd0);
    cyc(1'b1, 32'h1234_5678);
    check("R1 default offset 0 valid", {31'd0, res_valid}, 32'd1);
    check("R1 default offset 0 word",  res_word, 32'hA5A5_0F0F);

    // vector table: R3, R4, R5
    for (int i = 0; i < NV; i++) begin
      do_clear();
      set_off(TV_OFF[i]);
      cyc(1'b1, TV_PREV[i]);
      check("R2 table prime", {31'd0, res_valid}, 32'd0);
      cyc(1'b1, TV_NEW[i]);
      check("R3 table valid", {31'd0, res_valid}, 32'd1);
      check(TV_OFF[i] == 2'd0 ? "R4 table word" :
            (i == 2 ? "R5 table word" : "R3 table word"), res_word, TV_EXP[i]);
    end

    // R6 back-to-back chain, offset 2
    do_clear();
    set_off(2'd2);
    src_valid = 1'b1; src_word = 32'h03020100;
    @(negedge clk);
    check("R6 chain prime", {31'd0, res_valid}, 32'd0);
    src_word = 32'h07060504; @(negedge clk);
    check("R6 chain 1", res_word, 32'h05040302);
    src_word = 32'h0B0A0908; @(negedge clk);
    check("R6 chain 2", res_word, 32'h09080706);
    check("R6 chain 2 valid", {31'd0, res_valid}, 32'd1);
    src_word = 32'h0F0E0D0C; @(negedge clk);
    check("R6 chain 3", res_word, 32'h0D0C0B0A);
    src_valid = 1'b0; @(negedge clk);
    check("R9 valid drops", {31'd0, res_valid}, 32'd0);
    check("R9 word held",   res_word, 32'h0D0C0B0A);

    // R7 offset change timing
    do_clear();
    set_off(2'd1);
    cyc(1'b1, 32'h03020100);
    off_we = 1'b1; off_wdata = 2'd3;
    cyc(1'b1, 32'h07060504);
    off_we = 1'b0;
    check("R7 same-cycle write uses old offset", res_word, 32'h04030201);
    cyc(1'b1, 32'h0B0A0908);
    check("R7 new offset applied", res_word, 32'h0A090807);
    set_off(2'd0);
    check("R9 idle write no result", {31'd0, res_valid}, 32'd0);
    check("R9 idle write holds word", res_word, 32'h0A090807);
    cyc(1'b1, 32'h0F0E0D0C);
    check("R7 saved word kept across write", res_word, 32'h0B0A0908);

    // R8 clear mid-stream, with a word offered in the clear cycle
    clr = 1'b1; src_valid = 1'b1; src_word = 32'hFFFF_FFFF;
    @(negedge clk);
    clr = 1'b0; src_valid = 1'b0;
    check("R8 clear no result", {31'd0, res_valid}, 32'd0);
    check("R8 clear priming",   {31'd0, priming},   32'd1);
    cyc(1'b1, 32'h4433_2211);
    check("R8 first after clear primes", {31'd0, res_valid}, 32'd0);
    cyc(1'b1, 32'h8877_6655);
    check("R8 second after clear valid", {31'd0, res_valid}, 32'd1);
    check("R8 second after clear word",  res_word, 32'h4433_2211);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule